// File: doc/BRIEF.md
# SPI Slave Memory Access Bridge

This block lets an external SPI host (mode 0: clock idles low, data sampled on the rising edge and changed on the falling edge) read and write a byte-addressed, little-endian memory that is 64 bits wide. The host lowers chip select and sends a command byte and then a 32-bit address. Each byte on the wire goes most significant bit first, and the four address bytes go most significant byte first. Data follows in words. The command picks the word size: 2 bytes, 4 bytes, or a run of 8-byte burst words.

Each data word travels on the wire with its most significant byte first. In memory the same word is stored little-endian, so the bridge reverses the byte order between wire and memory. A read returns four dummy bytes before its data, and the host sends one dummy byte after the data of a write. The SPI pins pass through a two-flop synchroniser clocked by the system clock, so the SPI clock has to be several times slower than the system clock. On the memory side there is one synchronous port with per-byte write enables and a read latency of one cycle.

Top module: `spi_mem_bridge`

## Requirements
- R1: Command codes are 0x00 read 2-byte, 0x01 write 2-byte, 0x02 read 4-byte, 0x03 write 4-byte, 0x04 read burst, 0x05 write burst. Any other command byte aborts the transaction: there is no memory access and MISO stays 0 until chip select rises.
- R2: The four bytes after the command form the byte address, most significant byte first. A memory access uses address bits [31:3] as `mem_addr`.
- R3: A 2-byte write (0x01) at byte address A takes two data bytes. The first byte lands in lane A[2:0]+1 and the second in lane A[2:0], and `mem_we` enables only those two lanes.
- R4: A 4-byte write (0x03) at A takes four data bytes. Wire byte k (k = 0..3) lands in lane A[2:0]+3-k, and `mem_we` enables only those four lanes.
- R5: In a burst write (0x05), every 8 data bytes cause one write with `mem_we` = 0xFF. Wire byte k of a word goes to lane 7-k. The word address grows by 1 (8 bytes) per word.
- R6: A burst moves at most 240 data bytes (30 words). Further data bytes in the same transaction cause no memory access.
- R7: A 2-byte or 4-byte read at A returns four 0x00 dummy bytes after the address. It then returns the word's bytes most significant first, so byte k comes from byte address A+W-1-k, where W is the word size.
- R8: A burst read (0x04) returns 8-byte words back to back with no gap, each most significant byte first. The address advances by 8 per word.
- R9: A word that is not complete when chip select rises, including the trailing dummy byte of a write, is discarded with no write. There is no memory access while chip select is high.
- R10: An address not aligned to the command's word size (2, 4 or 8 bytes) aborts the transaction with no memory access and a zero MISO.
- R11: MISO is 0 while the command, address and dummy bytes shift and while chip select is high.
- R12: During and right after reset, `mem_en` and `mem_we` are 0 and MISO is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI clock from the host, mode 0 |
| spi_cs_n | input | 1 | Active-low chip select framing one transaction |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| mem_en | output | 1 | Memory access strobe, one cycle per word |
| mem_we | output | 8 | Per-lane write enables. All zero with `mem_en` means a read |
| mem_addr | output | 29 | Word address, byte address bits [31:3] |
| mem_wdata | output | 64 | Write data, lane n is bits [8n+7:8n] |
| mem_rdata | input | 64 | Read data, valid the cycle after a read strobe |

## Verification
A wrong internal state shows up at the ports within one byte time, about 16 SPI half-periods, or on the next memory strobe. A lane index that is off appears as a wrong `mem_we` pattern or as a swapped byte in the MISO stream. A word counter that is off causes a write too many or too few at the burst limit. A phase counter that is off moves the first data byte into a dummy slot, so the bytes compared on the wire break at once. Abort and discard paths are seen only as the absence of memory strobes, so the bench counts every strobe and compares the count across each transaction that must not touch memory.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  typedef enum logic [2:0] {
    CMD_RD16 = 3'd0,
    CMD_WR16 = 3'd1,
    CMD_RD32 = 3'd2,
    CMD_WR32 = 3'd3,
    CMD_RDBR = 3'd4,
    CMD_WRBR = 3'd5
  } cmd_e;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_SKIP
  } phase_e;
endpackage

// File: rtl/spi_sync_bank.sv
module spi_sync_bank #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= RST_VAL;
      else     chain[s] <= (s == 0) ? d : chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_byte_io.sv
module spi_byte_io (
  input  logic       clk,
  input  logic       rst,
  input  logic       sclk_s,
  input  logic       cs_n_s,
  input  logic       mosi_s,
  input  logic [7:0] tx_byte,
  output logic [7:0] rx_byte,
  output logic       rx_valid,
  output logic       miso
);
  logic       sclk_q;
  logic [2:0] bit_cnt;
  logic [7:0] rx_sh;
  logic [7:0] tx_sh;
  logic       rise, fall;

  assign rise = sclk_s & ~sclk_q;
  assign fall = ~sclk_s & sclk_q;
  assign miso = tx_sh[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q   <= 1'b0;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
    end else begin
      sclk_q   <= sclk_s;
      rx_valid <= 1'b0;
      if (cs_n_s) begin
        bit_cnt <= '0;
        tx_sh   <= '0;
      end else begin
        if (rise) begin
          rx_sh   <= {rx_sh[6:0], mosi_s};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            rx_byte  <= {rx_sh[6:0], mosi_s};
            rx_valid <= 1'b1;
          end
        end
        if (fall) begin
          if (bit_cnt == 3'd0) tx_sh <= tx_byte;
          else                 tx_sh <= {tx_sh[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES = 8,
  parameter int BURST_MAX_BYTES = 240
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cs_n_s,
  input  logic                          rx_valid,
  input  logic [7:0]                    rx_byte,
  output logic [7:0]                    tx_byte,
  output logic                          mem_en,
  output logic [LANES-1:0]              mem_we,
  output logic [ADDR_W-$clog2(LANES)-1:0] mem_addr,
  output logic [8*LANES-1:0]            mem_wdata,
  input  logic [8*LANES-1:0]            mem_rdata
);
  localparam int LB   = $clog2(LANES);
  localparam int DW   = 8 * LANES;
  localparam int MAXW = BURST_MAX_BYTES / LANES;
  localparam int WCW  = $clog2(MAXW + 1);

  phase_e           state;
  logic [2:0]       cmd;
  logic [ADDR_W-1:0] addr;
  logic [LB-1:0]    k;
  logic [WCW-1:0]   words;
  logic [1:0]       dcnt;
  logic [DW-1:0]    wbuf, wbuf_n, rd_word;
  logic [LANES-1:0] wbe, wbe_n;
  logic [1:0]       rd_pend;

  logic [LB-1:0]     wlast, lane_sel, nlast;
  logic [ADDR_W-1:0] addr_full, addr_inc;
  logic              is_rd, is_burst, more_words;

  function automatic logic [LB-1:0] last_idx(input logic [2:0] c);
    case (c[2:1])
      2'd0:    return LB'(1);
      2'd1:    return LB'(3);
      default: return LB'(LANES - 1);
    endcase
  endfunction

  function automatic logic [7:0] pick(input logic [DW-1:0] w, input logic [LB-1:0] l);
    return w[{l, 3'b000} +: 8];
  endfunction

  always_comb begin
    wlast      = last_idx(cmd);
    is_rd      = ~cmd[0];
    is_burst   = cmd[2];
    lane_sel   = addr[LB-1:0] + wlast - k;
    addr_full  = {addr[ADDR_W-9:0], rx_byte};
    addr_inc   = addr + ADDR_W'(LANES);
    nlast      = last_idx(cmd);
    more_words = is_burst && (words < WCW'(MAXW - 1));
    wbuf_n     = wbuf;
    wbe_n      = wbe;
    wbuf_n[{lane_sel, 3'b000} +: 8] = rx_byte;
    wbe_n[lane_sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_CMD;
      cmd       <= '0;
      addr      <= '0;
      k         <= '0;
      words     <= '0;
      dcnt      <= '0;
      wbuf      <= '0;
      wbe       <= '0;
      rd_word   <= '0;
      rd_pend   <= '0;
      tx_byte   <= '0;
      mem_en    <= 1'b0;
      mem_we    <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_en  <= 1'b0;
      mem_we  <= '0;
      rd_pend <= {rd_pend[0], 1'b0};
      if (rd_pend[1]) rd_word <= mem_rdata;
      if (cs_n_s) begin
        state   <= ST_CMD;
        k       <= '0;
        words   <= '0;
        dcnt    <= '0;
        wbe     <= '0;
        tx_byte <= '0;
      end else if (rx_valid) begin
        case (state)
          ST_CMD: begin
            cmd  <= rx_byte[2:0];
            dcnt <= '0;
            state <= (rx_byte > 8'd5) ? ST_SKIP : ST_ADDR;
          end
          ST_ADDR: begin
            addr <= addr_full;
            dcnt <= dcnt + 2'd1;
            if (dcnt == 2'd3) begin
              if ((addr_full[LB-1:0] & nlast) != '0) begin
                state <= ST_SKIP;
              end else if (is_rd) begin
                mem_en   <= 1'b1;
                mem_addr <= addr_full[ADDR_W-1:LB];
                rd_pend  <= {rd_pend[0], 1'b1};
                state    <= ST_DUMMY;
              end else begin
                state <= ST_DATA;
              end
            end
          end
          ST_DUMMY: begin
            dcnt <= dcnt + 2'd1;
            if (dcnt == 2'd3) begin
              tx_byte <= pick(rd_word, lane_sel);
              state   <= ST_DATA;
            end
          end
          ST_DATA: begin
            if (is_rd) begin
              if (k == wlast) begin
                if (more_words) begin
                  words   <= words + WCW'(1);
                  addr    <= addr_inc;
                  k       <= '0;
                  tx_byte <= pick(rd_word, LB'(LANES - 1));
                end else begin
                  state   <= ST_SKIP;
                  tx_byte <= '0;
                end
              end else begin
                k       <= k + LB'(1);
                tx_byte <= pick(rd_word, lane_sel - LB'(1));
                if (more_words && k == wlast - LB'(1)) begin
                  mem_en   <= 1'b1;
                  mem_addr <= addr_inc[ADDR_W-1:LB];
                  rd_pend  <= {rd_pend[0], 1'b1};
                end
              end
            end else begin
              wbuf <= wbuf_n;
              wbe  <= wbe_n;
              if (k == wlast) begin
                mem_en    <= 1'b1;
                mem_we    <= wbe_n;
                mem_addr  <= addr[ADDR_W-1:LB];
                mem_wdata <= wbuf_n;
                wbe       <= '0;
                k         <= '0;
                if (more_words) begin
                  words <= words + WCW'(1);
                  addr  <= addr_inc;
                end else begin
                  state <= ST_SKIP;
                end
              end else begin
                k <= k + LB'(1);
              end
            end
          end
          default: tx_byte <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_mem_bridge.sv
module spi_mem_bridge #(
  parameter int ADDR_W = 32,
  parameter int LANES = 8,
  parameter int BURST_MAX_BYTES = 240,
  parameter int SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            spi_sclk,
  input  logic                            spi_cs_n,
  input  logic                            spi_mosi,
  output logic                            spi_miso,
  output logic                            mem_en,
  output logic [LANES-1:0]                mem_we,
  output logic [ADDR_W-$clog2(LANES)-1:0] mem_addr,
  output logic [8*LANES-1:0]              mem_wdata,
  input  logic [8*LANES-1:0]              mem_rdata
);
  logic [2:0] pins_s;
  logic       rx_valid;
  logic [7:0] rx_byte, tx_byte;

  spi_sync_bank #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst),
    .d({spi_sclk, spi_cs_n, spi_mosi}),
    .q(pins_s)
  );

  spi_byte_io u_io (
    .clk(clk), .rst(rst),
    .sclk_s(pins_s[2]), .cs_n_s(pins_s[1]), .mosi_s(pins_s[0]),
    .tx_byte(tx_byte), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .miso(spi_miso)
  );

  spi_mem_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .BURST_MAX_BYTES(BURST_MAX_BYTES)) u_ctrl (
    .clk(clk), .rst(rst), .cs_n_s(pins_s[1]),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_byte(tx_byte),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );
endmodule

// File: rtl/spi_mem_bridge_chk.sv
module spi_mem_bridge_chk #(
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             spi_cs_n,
  input logic             spi_miso,
  input logic             mem_en,
  input logic [LANES-1:0] mem_we
);
  assert_we_only_with_en_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_we != '0) |-> mem_en);

  assert_lane_count_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we != '0) |->
      ($countones(mem_we) == 2 || $countones(mem_we) == 4 || $countones(mem_we) == LANES));

  assert_no_access_deselected_R9: assert property (@(posedge clk) disable iff (rst)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !mem_en);

  assert_miso_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso);

  assert_reset_idle_R12: assert property (@(posedge clk)
    $past(rst) |-> (!mem_en && mem_we == '0));
endmodule

bind spi_mem_bridge spi_mem_bridge_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
  .mem_en(mem_en), .mem_we(mem_we)
);

// File: tb/spi_mem_bridge_test.sv
module spi_mem_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam logic [31:0] BASE = 32'h6003_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic        spi_miso, mem_en;
  logic [7:0]  mem_we;
  logic [28:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_mem_bridge uut (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  typedef struct {
    logic [28:0] a;
    logic [7:0]  we;
    logic [63:0] d;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          checks = 0, errors = 0, accesses = 0;
  bit          done = 1'b0;
  logic [63:0] mem [64];

  function automatic logic [7:0] pat(input logic [31:0] x);
    return x[7:0] ^ 8'h3C;
  endfunction

  initial begin
    for (int w = 0; w < 64; w++)
      for (int b = 0; b < 8; b++) mem[w][8*b +: 8] = pat(32'(w*8 + b));
  end

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we == '0) mem_rdata <= mem[mem_addr[5:0]];
      else for (int b = 0; b < 8; b++)
        if (mem_we[b]) mem[mem_addr[5:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every write strobe
  always @(negedge clk) begin
    if (!rst && mem_en) begin
      accesses++;
      if (mem_we != '0) begin
        if (q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R9: actual unexpected write addr %h we %h expected none", mem_addr, mem_we);
        end else begin
          exp_t e;
          logic [63:0] m;
          e = q.pop_front();
          for (int b = 0; b < 8; b++) m[8*b +: 8] = {8{e.we[b]}};
          check({e.tag, " addr"}, 64'(mem_addr), 64'(e.a));
          check({e.tag, " we"}, 64'(mem_we), 64'(e.we));
          check({e.tag, " data"}, mem_wdata & m, e.d & m);
        end
      end
    end
  end

  task automatic push(input logic [31:0] a, input logic [7:0] we, input logic [63:0] d, input string tag);
    exp_t e;
    e.a = a[31:3]; e.we = we; e.d = d; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = spi_miso;
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic begin_txn(input logic [7:0] cmd, input logic [31:0] a);
    logic [7:0] r;
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    xfer(cmd, r);
    check("R11 cmd byte miso", 64'(r), 64'h0);
    for (int i = 3; i >= 0; i--) begin
      xfer(a[8*i +: 8], r);
      check("R11 addr byte miso", 64'(r), 64'h0);
    end
  endtask

  task automatic end_txn();
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (6*HALF) @(negedge clk);
  endtask

  task automatic read_txn(input logic [7:0] cmd, input logic [31:0] a, input int n, input string tag);
    logic [7:0] r;
    begin_txn(cmd, a);
    for (int i = 0; i < 4; i++) begin
      xfer(8'h00, r);
      check("R7 dummy byte zero", 64'(r), 64'h0);
    end
    for (int i = 0; i < n; i++) begin
      int w;
      logic [31:0] ea;
      w = (cmd == 8'h04) ? 8 : (cmd == 8'h02 ? 4 : 2);
      ea = a + 32'((i / w) * w + (w - 1 - (i % w)));
      xfer(8'h00, r);
      check(tag, 64'(r), 64'(pat(ea)));
    end
    end_txn();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] r;
    int base_acc;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R12 reset mem_en", 64'(mem_en), 64'h0);
    check("R12 reset mem_we", 64'(mem_we), 64'h0);
    check("R12 reset miso", 64'(spi_miso), 64'h0);

    read_txn(8'h00, BASE + 32'h02, 2, "R7 read16 byte");
    read_txn(8'h02, BASE + 32'h04, 4, "R7 read32 byte");
    read_txn(8'h04, BASE + 32'h08, 24, "R8 burst read byte");

    // R3: 2-byte write at offset 2 -> lanes 3 and 2
    push(BASE + 32'h102, 8'h0C, 64'h0000_0000_ABCD_0000, "R3 wr16");
    begin_txn(8'h01, BASE + 32'h102);
    xfer(8'hAB, r); xfer(8'hCD, r); xfer(8'h00, r);
    end_txn();

    // R4: 4-byte write at offset 4 -> lanes 7..4
    push(BASE + 32'h104, 8'hF0, 64'h1122_3344_0000_0000, "R4 wr32");
    begin_txn(8'h03, BASE + 32'h104);
    xfer(8'h11, r); xfer(8'h22, r); xfer(8'h33, r); xfer(8'h44, r); xfer(8'h00, r);
    end_txn();

    // R5 + R2: two burst words, trailing dummy discarded (R9)
    push(BASE + 32'h108, 8'hFF, 64'hA0A1_A2A3_A4A5_A6A7, "R5 burst w0");
    push(BASE + 32'h110, 8'hFF, 64'hA8A9_AAAB_ACAD_AEAF, "R5 burst w1");
    begin_txn(8'h05, BASE + 32'h108);
    for (int i = 0; i < 16; i++) xfer(8'hA0 + 8'(i), r);
    xfer(8'h00, r);
    end_txn();

    // R6: 31 words offered, 30 written
    base_acc = accesses;
    for (int w = 0; w < 30; w++) begin
      logic [63:0] d;
      for (int b = 0; b < 8; b++) d[8*(7-b) +: 8] = 8'(w*8 + b + 1);
      push(BASE + 32'h100 + 32'(w*8), 8'hFF, d, "R6 burst cap");
    end
    begin_txn(8'h05, BASE + 32'h100);
    for (int n = 0; n < 248; n++) xfer(8'(n + 1), r);
    xfer(8'h00, r);
    end_txn();
    check("R6 access count", 64'(accesses - base_acc), 64'd30);

    // R1: unknown command
    base_acc = accesses;
    begin_txn(8'h07, BASE + 32'h200);
    for (int i = 0; i < 8; i++) begin
      xfer(8'h5A, r);
      check("R1 unknown cmd miso", 64'(r), 64'h0);
    end
    end_txn();
    check("R1 unknown cmd no access", 64'(accesses - base_acc), 64'h0);

    // R10: misaligned write and read
    base_acc = accesses;
    begin_txn(8'h03, BASE + 32'h102);
    for (int i = 0; i < 5; i++) xfer(8'h77, r);
    end_txn();
    begin_txn(8'h04, BASE + 32'h04);
    for (int i = 0; i < 12; i++) begin
      xfer(8'h00, r);
      check("R10 misaligned read miso", 64'(r), 64'h0);
    end
    end_txn();
    check("R10 misaligned no access", 64'(accesses - base_acc), 64'h0);

    // R9: partial burst word cut by chip select
    base_acc = accesses;
    begin_txn(8'h05, BASE + 32'h180);
    for (int i = 0; i < 5; i++) xfer(8'h99, r);
    end_txn();
    check("R9 partial word no access", 64'(accesses - base_acc), 64'h0);

    repeat (20) @(negedge clk);
    check("R9 scoreboard drained", 64'(q.size()), 64'h0);
    done = 1'b1;
    finish_run();
  end
endmodule